// File: doc/BRIEF.md
# Delayed interrupt enable controller

This block sits beside a CPU sequencer and decides, once per instruction, whether a pending interrupt request is accepted. The sequencer raises a check strobe at the interrupt-check point between instructions. The block holds a master interrupt-enable flag and a one-instruction delay flag. When the enable instruction runs, both flags are set. At the following check the delay flag blocks service, so the instruction after the enable (normally a return from interrupt) can complete before any interrupt is taken.

Every check clears the delay flag. A request that the delay flag holds back is taken at the next check, provided it is still asserted. Accepting an interrupt produces a single-cycle taken pulse and clears the enable flag, so a nested interrupt cannot be taken until software enables interrupts again. The disable instruction clears both flags. Saving the program counter, vectoring and priority between devices are handled elsewhere.

Top module: `intr_gate`

## Requirements
- R1: After asynchronous reset (rst_n low), ie_o, delay_o and taken_o are all 0.
- R2: An enable strobe (en_i=1, dis_i=0) makes ie_o and delay_o read 1 in the cycle after the strobe's clock edge.
- R3: A check strobe while delay_o=1 takes no interrupt, even when ie_o=1 and irq_i=1. delay_o reads 0 after that check.
- R4: When check_i=1, ie_o=1, irq_i=1 and delay_o=0 at a clock edge, taken_o is 1 for exactly the one cycle that follows that edge.
- R5: Taking an interrupt clears ie_o at the same edge that raises taken_o. This holds even when an enable strobe arrives at that edge. In that case delay_o still reads 1.
- R6: A request held back by the delay flag and still asserted is taken at the next check strobe.
- R7: A disable strobe (dis_i=1) makes ie_o=0 and delay_o=0 in the following cycle.
- R8: When en_i and dis_i are both 1 at the same edge, the disable wins: ie_o=0 and delay_o=0 afterwards.
- R9: A check with irq_i=0, or with ie_o=0, takes no interrupt. It still clears delay_o.
- R10: When en_i and check_i are both 1 at the same edge (with dis_i=0), the enable wins for the delay flag: delay_o reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable-interrupts instruction strobe |
| dis_i | input | 1 | Disable-interrupts instruction strobe |
| irq_i | input | 1 | Level interrupt request |
| check_i | input | 1 | Interrupt-check strobe from the sequencer |
| taken_o | output | 1 | One-cycle pulse: interrupt accepted |
| ie_o | output | 1 | Interrupt-enable flag |
| delay_o | output | 1 | One-instruction delay flag |

## Verification
Every result is registered, so each output responds one cycle after the clock edge that samples the strobes: the flags and the taken pulse all change at the edge that follows the input. The bench drives inputs on the falling edge and pushes the expected flag and pulse values for that step into a queue. A monitor pops each entry a quarter period after the next rising edge and compares it. Each entry therefore meets the exact cycle in which its result is due, and a pulse that comes early, comes late or lasts two cycles shows up as a mismatch.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;

    // Operation applied to a single flag bit
    typedef enum logic [1:0] {
        FOP_HOLD = 2'd0,
        FOP_CLR  = 2'd1,
        FOP_SET  = 2'd2
    } flag_op_e;

    // Next-state bundle computed by the top-level control
    typedef struct packed {
        flag_op_e ie_op;
        flag_op_e dly_op;
        logic     taken;
    } ctrl_next_t;

endpackage

// File: rtl/flag_reg.sv
module flag_reg
    import intr_gate_pkg::*;
#(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  flag_op_e op_i,
    output logic     q_o
);

    logic flag_d;
    logic flag_q;

    always_comb begin
        case (op_i)
            FOP_CLR: flag_d = 1'b0;
            FOP_SET: flag_d = 1'b1;
            default: flag_d = flag_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= RESET_VAL;
        else        flag_q <= flag_d;
    end

    assign q_o = flag_q;

endmodule

// File: rtl/take_decide.sv
module take_decide (
    input  logic check_i,
    input  logic irq_i,
    input  logic ie_i,
    input  logic dly_i,
    output logic take_o
);

    always_comb begin
        take_o = check_i && irq_i && ie_i && !dly_i;
    end

endmodule

// File: rtl/intr_gate.sv
module intr_gate
    import intr_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic dis_i,
    input  logic irq_i,
    input  logic check_i,
    output logic taken_o,
    output logic ie_o,
    output logic delay_o
);

    ctrl_next_t nxt_d;
    logic       take_w;
    logic       ie_q;
    logic       dly_q;
    logic       taken_q;

    take_decide u_take (
        .check_i (check_i),
        .irq_i   (irq_i),
        .ie_i    (ie_q),
        .dly_i   (dly_q),
        .take_o  (take_w)
    );

    always_comb begin
        nxt_d.taken = take_w;

        // Enable flag: any clear source beats the enable strobe
        if (dis_i || take_w)  nxt_d.ie_op = FOP_CLR;
        else if (en_i)        nxt_d.ie_op = FOP_SET;
        else                  nxt_d.ie_op = FOP_HOLD;

        // Delay flag: disable, then enable, then the check-step clear
        if (dis_i)            nxt_d.dly_op = FOP_CLR;
        else if (en_i)        nxt_d.dly_op = FOP_SET;
        else if (check_i)     nxt_d.dly_op = FOP_CLR;
        else                  nxt_d.dly_op = FOP_HOLD;
    end

    flag_reg #(.RESET_VAL(1'b0)) u_ie (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (nxt_d.ie_op),
        .q_o   (ie_q)
    );

    flag_reg #(.RESET_VAL(1'b0)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (nxt_d.dly_op),
        .q_o   (dly_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taken_q <= 1'b0;
        else        taken_q <= nxt_d.taken;
    end

    assign taken_o = taken_q;
    assign ie_o    = ie_q;
    assign delay_o = dly_q;

    // R2
    enable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !dis_i) |=> (delay_o && (ie_o || taken_o)));

    // R3
    delay_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (check_i && delay_o) |=> !taken_o);

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> !taken_o);

    // R5
    take_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> !ie_o);

    // R7
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> (!ie_o && !delay_o));

endmodule

// File: tb/tb_intr_gate.sv
module tb_intr_gate;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  taken;
        logic  ie;
        logic  dly;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0, dis_i = 1'b0, irq_i = 1'b0, check_i = 1'b0;
    logic taken_o, ie_o, delay_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_gate dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .dis_i   (dis_i),
        .irq_i   (irq_i),
        .check_i (check_i),
        .taken_o (taken_o),
        .ie_o    (ie_o),
        .delay_o (delay_o)
    );

    task automatic compare(input exp_t e);
        n_checks++;
        if (taken_o !== e.taken || ie_o !== e.ie || delay_o !== e.dly) begin
            n_fail++;
            $display("FAIL %s: taken/ie/delay got %b%b%b expected %b%b%b",
                     e.tag, taken_o, ie_o, delay_o, e.taken, e.ie, e.dly);
        end
    endtask

    // Driver: applies one step on the falling edge and queues its expectation
    task automatic step(input logic en, input logic dis, input logic irq,
                        input logic chk, input logic x_taken, input logic x_ie,
                        input logic x_dly, input string tag);
        exp_t e;
        @(negedge clk);
        en_i = en; dis_i = dis; irq_i = irq; check_i = chk;
        e.taken = x_taken; e.ie = x_ie; e.dly = x_dly; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    initial begin
        exp_t r;
        #(CLK_PERIOD*3);
        r.taken = 1'b0; r.ie = 1'b0; r.dly = 1'b0; r.tag = "R1 reset";
        compare(r);
        @(negedge clk) rst_n = 1'b1;

        step(0,0,1,1, 0,0,0, "R9 check with ie clear");
        step(1,0,1,0, 0,1,1, "R2 enable");
        step(0,0,1,1, 0,1,0, "R3 delayed check");
        step(0,0,1,1, 1,0,0, "R6 R4 R5 deferred take");
        step(0,0,1,0, 0,0,0, "R4 pulse ends");
        step(1,0,0,0, 0,1,1, "R2 enable again");
        step(0,0,0,1, 0,1,0, "R9 check no irq clears delay");
        step(0,0,0,1, 0,1,0, "R9 check no irq");
        step(0,1,0,0, 0,0,0, "R7 disable ie");
        step(1,0,0,0, 0,1,1, "R2 enable");
        step(0,1,0,0, 0,0,0, "R7 disable clears delay");
        step(1,1,0,0, 0,0,0, "R8 enable+disable");
        step(1,0,1,1, 0,1,1, "R10 enable with check");
        step(0,0,1,1, 0,1,0, "R3 delay blocks");
        step(0,0,1,0, 0,1,0, "R6 pending held no check");
        step(0,0,1,1, 1,0,0, "R6 R4 taken");
        step(1,0,0,0, 0,1,1, "R2 enable");
        step(0,0,0,1, 0,1,0, "R9 clear delay");
        step(1,0,1,1, 1,0,1, "R5 take beats enable");
        step(0,0,1,1, 0,0,0, "R9 ie clear after take");
        step(0,0,0,0, 0,0,0, "R4 idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 1000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule